// File: doc/BRIEF.md
# Convolution Kernel Configuration Registers

This block is the control side of a 3 x 3 image convolver. A host processor writes configuration through a plain bus with a 3-bit address, an 8-bit data word and a load strobe, and no glue logic sits in between. The block holds one small control register and two complete kernel banks. Each bank has nine 8-bit coefficients, A through I. The control register picks the operating mode, the number format and which bank the datapath uses. The block presents the active kernel and the control bits to the multiplier array as registered outputs.

A 3-bit address space is too narrow to reach eighteen coefficients one by one. Each bank therefore sits behind a single address and is loaded as a shift chain. Each write pushes a word in at coefficient A and moves every stored word one place toward I. Nine writes fill a bank, with the first word written ending up in I. Because there are two banks, software can load the idle bank while the datapath keeps filtering with the other. A single control write then swaps them. The frame synchronization input reaches this block but alters none of its registers.

Top module: `kernel_cfg_regs`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears the control bits, both banks and coef_out to zero by the following edge.
- R2: A write to address 0 loads the control register. Data bit 0 drives mode_1d, bit 1 drives fmt_signed and bit 2 drives bank_sel. Bits 7..3 are discarded. The new values appear one edge after the write.
- R3: A write to address 1 shifts bank 0. The data word becomes coefficient A, each of A..H moves to the next letter (A to B, ..., H to I), and the old I is dropped.
- R4: A write to address 2 shifts bank 1 in the same way as R3.
- R5: coef_out shows the bank chosen by bank_sel (0 selects bank 0, 1 selects bank 1). Coefficient A is at bits [7:0], B at [15:8], and so on up to I at [71:64]. It is registered, so it reflects register state one edge later: two edges after the write that changed it.
- R6: A write with address 3 through 7 changes no register.
- R7: While wr_load is low, no register changes whatever the address and data are.
- R8: Pulses on frame_sync change no register.
- R9: A write to one target leaves the other bank and the control register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| frame_sync | input | 1 | Frame start pulse from the video stream; affects no register |
| wr_load | input | 1 | Write enable for the configuration bus |
| wr_addr | input | 3 | Target select: 0 control, 1 bank 0, 2 bank 1 |
| wr_data | input | 8 | Write data |
| mode_1d | output | 1 | One-dimensional (9-tap) operating mode |
| fmt_signed | output | 1 | Pixel and coefficient data are two's complement |
| bank_sel | output | 1 | Active bank index |
| coef_out | output | 72 | Active kernel, A in the low byte |

## Verification
The hardest condition to reach from the ports is a bank that holds nine distinct values while it is not selected. That bank's contents cannot be seen at coef_out. The stimulus fills both banks with non-overlapping byte patterns, then flips bank_sel back and forth to bring each bank out and check that shifting one bank never disturbed the other. It also writes past nine words to show the oldest value falling off at I. It sends reserved addresses, idle-strobe traffic and frame pulses while both banks hold data, so any stray change would show up.

// File: rtl/kcfg_pkg.sv
package kcfg_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned TAPS   = 9;
  localparam int unsigned CTRL_W = 3;

  localparam logic [ADDR_W-1:0] ADR_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_BANK0 = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_BANK1 = 3'd2;

  typedef struct packed {
    logic bank_sel;
    logic fmt_signed;
    logic mode_1d;
  } ctrl_t;
endpackage

// File: rtl/kcfg_addr_decode.sv
module kcfg_addr_decode #(
  parameter int unsigned ADDR_W = 3
) (
  input  logic              wr_load,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic              ctrl_we,
  output logic              bank0_we,
  output logic              bank1_we
);
  import kcfg_pkg::*;

  always_comb begin
    ctrl_we  = 1'b0;
    bank0_we = 1'b0;
    bank1_we = 1'b0;
    if (wr_load) begin
      unique case (wr_addr)
        ADR_CTRL:  ctrl_we  = 1'b1;
        ADR_BANK0: bank0_we = 1'b1;
        ADR_BANK1: bank1_we = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/kcfg_ctrl_reg.sv
module kcfg_ctrl_reg #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CTRL_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [DATA_W-1:0] din,
  output logic [CTRL_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= din[CTRL_W-1:0];
  end

  logic unused_hi;
  assign unused_hi = ^din[DATA_W-1:CTRL_W];
endmodule

// File: rtl/kcfg_shift_bank.sv
module kcfg_shift_bank #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned TAPS   = 9,
  localparam int unsigned FLAT_W = DATA_W * TAPS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic [DATA_W-1:0] din,
  output logic [FLAT_W-1:0] taps_flat
);
  logic [DATA_W-1:0] tap [TAPS];

  always_ff @(posedge clk) begin
    if (rst)           tap[0] <= '0;
    else if (shift_en) tap[0] <= din;
  end

  for (genvar k = 1; k < TAPS; k++) begin : g_tap
    always_ff @(posedge clk) begin
      if (rst)           tap[k] <= '0;
      else if (shift_en) tap[k] <= tap[k-1];
    end
  end

  for (genvar k = 0; k < TAPS; k++) begin : g_pack
    assign taps_flat[k*DATA_W +: DATA_W] = tap[k];
  end
endmodule

// File: rtl/kcfg_bank_mux.sv
module kcfg_bank_mux #(
  parameter int unsigned FLAT_W = 72
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic [FLAT_W-1:0] bank0,
  input  logic [FLAT_W-1:0] bank1,
  output logic [FLAT_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= sel ? bank1 : bank0;
  end
endmodule

// File: rtl/kernel_cfg_regs.sv
module kernel_cfg_regs #(
  parameter int unsigned DATA_W = kcfg_pkg::DATA_W,
  parameter int unsigned ADDR_W = kcfg_pkg::ADDR_W,
  parameter int unsigned TAPS   = kcfg_pkg::TAPS,
  localparam int unsigned FLAT_W = DATA_W * TAPS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_sync,
  input  logic              wr_load,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              mode_1d,
  output logic              fmt_signed,
  output logic              bank_sel,
  output logic [FLAT_W-1:0] coef_out
);
  import kcfg_pkg::*;

  logic ctrl_we, bank0_we, bank1_we;
  logic [CTRL_W-1:0] ctrl_bits;
  ctrl_t             ctrl;
  logic [FLAT_W-1:0] bank0_flat;
  logic [FLAT_W-1:0] bank1_flat;

  // frame timing belongs to the datapath; configuration state ignores it
  logic unused_frame;
  assign unused_frame = frame_sync;

  kcfg_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .wr_load (wr_load),
    .wr_addr (wr_addr),
    .ctrl_we (ctrl_we),
    .bank0_we(bank0_we),
    .bank1_we(bank1_we)
  );

  kcfg_ctrl_reg #(.DATA_W(DATA_W), .CTRL_W(CTRL_W)) u_ctrl (
    .clk(clk), .rst(rst), .we(ctrl_we), .din(wr_data), .q(ctrl_bits)
  );

  kcfg_shift_bank #(.DATA_W(DATA_W), .TAPS(TAPS)) u_bank0 (
    .clk(clk), .rst(rst), .shift_en(bank0_we), .din(wr_data), .taps_flat(bank0_flat)
  );

  kcfg_shift_bank #(.DATA_W(DATA_W), .TAPS(TAPS)) u_bank1 (
    .clk(clk), .rst(rst), .shift_en(bank1_we), .din(wr_data), .taps_flat(bank1_flat)
  );

  assign ctrl       = ctrl_t'(ctrl_bits);
  assign mode_1d    = ctrl.mode_1d;
  assign fmt_signed = ctrl.fmt_signed;
  assign bank_sel   = ctrl.bank_sel;

  kcfg_bank_mux #(.FLAT_W(FLAT_W)) u_mux (
    .clk(clk), .rst(rst), .sel(ctrl.bank_sel),
    .bank0(bank0_flat), .bank1(bank1_flat), .q(coef_out)
  );
endmodule

// File: rtl/kcfg_checker.sv
module kcfg_checker #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned TAPS   = 9,
  localparam int unsigned FLAT_W = DATA_W * TAPS
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_load,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              mode_1d,
  input logic              fmt_signed,
  input logic              bank_sel,
  input logic [FLAT_W-1:0] coef_out,
  input logic [FLAT_W-1:0] bank0_flat,
  input logic [FLAT_W-1:0] bank1_flat
);
  logic [2:0] cfg;
  assign cfg = {bank_sel, fmt_signed, mode_1d};

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (cfg == 3'b000 && coef_out == '0));

  assert_ctrl_load_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_load && wr_addr == 3'd0) |=> cfg == $past(wr_data[2:0]));

  assert_bank0_shift_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_load && wr_addr == 3'd1) |=>
      (bank0_flat[DATA_W-1:0] == $past(wr_data) &&
       bank0_flat[FLAT_W-1:DATA_W] == $past(bank0_flat[FLAT_W-DATA_W-1:0]) &&
       $stable(bank1_flat)));

  assert_bank1_shift_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_load && wr_addr == 3'd2) |=>
      (bank1_flat[DATA_W-1:0] == $past(wr_data) &&
       bank1_flat[FLAT_W-1:DATA_W] == $past(bank1_flat[FLAT_W-DATA_W-1:0]) &&
       $stable(bank0_flat)));

  assert_bank_route_R5: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> coef_out == ($past(bank_sel) ? $past(bank1_flat) : $past(bank0_flat)));

  assert_reserved_addr_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_load && wr_addr > 3'd2) |=>
      ($stable(cfg) && $stable(bank0_flat) && $stable(bank1_flat)));

  assert_idle_strobe_R7: assert property (@(posedge clk) disable iff (rst)
    !wr_load |=> ($stable(cfg) && $stable(bank0_flat) && $stable(bank1_flat)));
endmodule

bind kernel_cfg_regs kcfg_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .TAPS(TAPS)) u_chk (
  .clk(clk), .rst(rst), .wr_load(wr_load), .wr_addr(wr_addr), .wr_data(wr_data),
  .mode_1d(mode_1d), .fmt_signed(fmt_signed), .bank_sel(bank_sel),
  .coef_out(coef_out), .bank0_flat(bank0_flat), .bank1_flat(bank1_flat)
);

// File: tb/sim_kernel_cfg_regs.sv
`timescale 1ns/1ps
module sim_kernel_cfg_regs;
  localparam int DW = 8;
  localparam int NT = 9;
  localparam int FW = DW * NT;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          frame_sync = 1'b0;
  logic          wr_load = 1'b0;
  logic [2:0]    wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          mode_1d, fmt_signed, bank_sel;
  logic [FW-1:0] coef_out;

  always #2 clk = ~clk;

  kernel_cfg_regs u0 (
    .clk(clk), .rst(rst), .frame_sync(frame_sync), .wr_load(wr_load),
    .wr_addr(wr_addr), .wr_data(wr_data), .mode_1d(mode_1d),
    .fmt_signed(fmt_signed), .bank_sel(bank_sel), .coef_out(coef_out)
  );

  typedef struct {
    string         tag;
    logic [2:0]    cfg;
    logic [FW-1:0] coef;
  } exp_t;

  exp_t exp_q[$];
  int   n_vec = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  logic [DW-1:0] m0 [NT];
  logic [DW-1:0] m1 [NT];
  logic [2:0]    mcfg;

  function automatic logic [FW-1:0] pack(input logic [DW-1:0] b [NT]);
    logic [FW-1:0] r;
    for (int k = 0; k < NT; k++) r[k*DW +: DW] = b[k];
    return r;
  endfunction

  task automatic model_clear();
    for (int k = 0; k < NT; k++) begin m0[k] = '0; m1[k] = '0; end
    mcfg = '0;
  endtask

  // one write per call; strobe left as is for back-to-back traffic
  task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
    wr_load = 1'b1; wr_addr = a; wr_data = d;
    if (a == 3'd0) mcfg = d[2:0];
    else if (a == 3'd1) begin
      for (int k = NT-1; k > 0; k--) m0[k] = m0[k-1];
      m0[0] = d;
    end else if (a == 3'd2) begin
      for (int k = NT-1; k > 0; k--) m1[k] = m1[k-1];
      m1[0] = d;
    end
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    wr_load = 1'b0;
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // results settle two edges after the last write; push after that edge
  task automatic expect_now(input string tag);
    exp_t e;
    wr_load = 1'b0;
    @(posedge clk); #1;
    e.tag  = tag;
    e.cfg  = mcfg;
    e.coef = mcfg[2] ? pack(m1) : pack(m0);
    exp_q.push_back(e);
    @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_vec++;
      if ({bank_sel, fmt_signed, mode_1d} !== e.cfg || coef_out !== e.coef) begin
        n_bad++;
        $display("FAIL %s: cfg=%b coef=%h expected cfg=%b coef=%h",
                 e.tag, {bank_sel, fmt_signed, mode_1d}, coef_out, e.cfg, e.coef);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_bad++; n_vec++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    expect_now("R1 reset state");

    // R2: control bits with junk in upper bits
    wr(3'd0, 8'hF9); expect_now("R2 ctrl 001 upper ignored");
    wr(3'd0, 8'h02); expect_now("R2 ctrl signed");
    wr(3'd0, 8'h00); expect_now("R2 ctrl clear");

    // R3: partial fill then full fill of bank 0
    wr(3'd1, 8'h11); wr(3'd1, 8'h22); wr(3'd1, 8'h33);
    expect_now("R3 bank0 three words");
    for (int i = 0; i < NT; i++) wr(3'd1, 8'(8'hA0 + i));
    expect_now("R3 bank0 full, first word at I");
    wr(3'd1, 8'h5C); expect_now("R3 tenth word drops old I");

    // R4 / R9: fill bank 1 while bank 0 is shown
    for (int i = 0; i < NT; i++) wr(3'd2, 8'(8'hC0 + 3*i));
    expect_now("R9 bank0 intact after bank1 fill");
    wr(3'd0, 8'h04); expect_now("R4 R5 bank1 selected");
    wr(3'd0, 8'h07); expect_now("R2 all ctrl bits set");

    // R9: writing bank 0 while bank 1 active
    wr(3'd1, 8'hEE); expect_now("R9 bank1 output unchanged");
    wr(3'd0, 8'h03); expect_now("R5 R9 back to bank0 with EE");

    // R6: reserved addresses
    for (int a = 3; a < 8; a++) wr(3'(a), 8'hFF);
    expect_now("R6 reserved addresses ignored");

    // R7: strobe low traffic
    wr_load = 1'b0;
    for (int a = 0; a < 8; a++) begin wr_addr = 3'(a); wr_data = 8'h5A; @(negedge clk); end
    expect_now("R7 idle strobe ignored");

    // R8: frame pulses
    for (int i = 0; i < 4; i++) begin
      frame_sync = 1'b1; @(negedge clk); frame_sync = 1'b0; @(negedge clk);
    end
    expect_now("R8 frame pulses ignored");
    wr(3'd0, 8'h04); expect_now("R8 bank1 after frames");

    // R1: reset mid-operation
    rst = 1'b1; wr(3'd2, 8'h99); rst = 1'b0;
    model_clear();
    expect_now("R1 reset clears all");
    wr(3'd0, 8'h04); expect_now("R1 bank1 cleared");

    idle(3);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule